// File: doc/BRIEF.md
# Interleaved Video RAM Arbiter

This block shares three byte-wide video memory banks between two users on a fixed time-division schedule. A display scanner reads the same row of all three banks in one access and receives a 24-bit word. A host port, driven by either a processor or a block-copy DMA engine, sees the three banks as one flat byte-addressed space in which consecutive addresses rotate through the banks. Every period of `PERIOD` clocks (12 by default, one microsecond at 12 MHz) holds exactly one scanner slot and one host slot. Neither user ever waits on the other, and a host request that arrives outside its slot is held off with a wait signal.

The host port has three operations. A read returns one byte. A write stores a byte, and either nibble can be enabled on its own. A copy stores a byte taken from one of two sources. If the source is external, the byte comes in on the write-data port and the copy finishes in one host slot. If the source is inside video memory, the first host slot reads the source byte and the next host slot writes it, so the copy takes two periods.

The banks are plain synchronous RAMs with `2**ROW_W` rows each. The default `ROW_W` of 9 keeps elaboration small; 14 gives the full 16K-row banks.

Top module: `vram_arbiter`

## Requirements
- R1: A phase counter runs 0 to 11 and then wraps. The cycle in which reset is first released is phase 0. The scanner slot is phase 0 and the host slot is phase 6, so scanner accesses are exactly 12 cycles apart.
- R2: In phase 0 the block samples `scan_addr` and reads that row from all three banks. In phase 2 `scan_valid` is high for one cycle, and `scan_data` carries bank 2 in bits 23:16, bank 1 in bits 15:8 and bank 0 in bits 7:0. `scan_data` holds that value until the next period.
- R3: A host byte address A is in bank A mod 3 at row A div 3. An address is in range when A < 3·2^ROW_W.
- R4: `host_wait` equals `host_req` in every cycle except the cycle in which the request is accepted. Acceptance happens only in phase 6.
- R5: A read accepted in phase 6 shows its byte on `host_rdata` from phase 8 of the same period. `host_rdata` keeps that byte until the next read or copy result.
- R6: A write (`host_op` = 1) updates bits 3:0 when `host_nib[0]` is set and bits 7:4 when `host_nib[1]` is set. Each enabled nibble is written on its own.
- R7: A write or copy with `host_nib` = 00 leaves the memory unchanged.
- R8: An out-of-range read, including the source read of a copy, returns 0xFF. An out-of-range write changes no bank.
- R9: A copy (`host_op` = 2) with `host_src_vram` = 1 reads `host_src_addr` in one host slot and writes the byte to `host_addr` in the next host slot, under `host_nib`. `host_wait` stays high through the first of these slots.
- R10: A copy with `host_src_vram` = 0 writes `host_wdata` to `host_addr`, under `host_nib`, in the first host slot.
- R11: While reset is asserted, `scan_valid`, `scan_data` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_addr | input | ROW_W | Row the scanner reads |
| scan_data | output | 24 | Three bank bytes of the scanned row |
| scan_valid | output | 1 | One-cycle strobe for a new `scan_data` |
| host_req | input | 1 | Host request, held until `host_wait` is low |
| host_op | input | 2 | 0 read, 1 write, 2 copy |
| host_addr | input | ADDR_W | Byte address for a read or write, and copy destination |
| host_src_addr | input | ADDR_W | Copy source address when the source is in video memory |
| host_src_vram | input | 1 | Copy source is video memory (1) or `host_wdata` (0) |
| host_nib | input | 2 | Nibble write enables: bit 0 low nibble, bit 1 high nibble |
| host_wdata | input | 8 | Write data, or copy data from an external source |
| host_rdata | output | 8 | Last read result |
| host_wait | output | 1 | Request not completed in this cycle |

## Verification
The assertions assume the host holds `host_req` and every host field steady from the cycle it raises the request until the cycle `host_wait` goes low. The copy-stage tracking and the no-write properties depend on this. The bench changes inputs only 2 ns after a rising edge. Each operation task raises the request, waits for `host_wait` to fall at a falling edge, and drops the request only after the accepting edge. `scan_addr` may change at any time, because only its value at the phase-0 edge matters.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  localparam int unsigned NBANKS = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_COPY  = 2'd2
  } host_op_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_HOST = 2'd1,
    RD_COPY = 2'd2
  } rd_kind_e;

  // Bank that holds a flat host byte address.
  function automatic int unsigned bank_of(input int unsigned a);
    return a % NBANKS;
  endfunction

  // Row inside that bank.
  function automatic int unsigned row_of(input int unsigned a);
    return a / NBANKS;
  endfunction

  function automatic logic in_window(input int unsigned a, input int unsigned rows);
    return a < (NBANKS * rows);
  endfunction

  // Replace the enabled nibbles of old_b with those of new_b.
  function automatic logic [7:0] nib_merge(input logic [7:0] old_b,
                                           input logic [7:0] new_b,
                                           input logic [1:0] en);
    logic [7:0] r;
    r      = old_b;
    if (en[0]) r[3:0] = new_b[3:0];
    if (en[1]) r[7:4] = new_b[7:4];
    return r;
  endfunction

endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer #(
  parameter int PERIOD  = 12,
  parameter int SCAN_AT = 0,
  parameter int HOST_AT = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic scan_slot,
  output logic host_slot
);
  localparam int PH_W = $clog2(PERIOD);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            phase <= '0;
    else if (phase == PH_W'(PERIOD - 1))   phase <= '0;
    else                                   phase <= phase + 1'b1;
  end

  assign scan_slot = (phase == PH_W'(SCAN_AT));
  assign host_slot = (phase == PH_W'(HOST_AT));
endmodule

// File: rtl/vram_bank.sv
module vram_bank import vram_arb_pkg::*; #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             en,
  input  logic [ROW_W-1:0] row,
  input  logic [1:0]       nib_we,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (|nib_we) mem[row] <= nib_merge(mem[row], wdata, nib_we);
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter import vram_arb_pkg::*; #(
  parameter int ROW_W   = 9,
  parameter int ADDR_W  = 16,
  parameter int PERIOD  = 12,
  parameter int HOST_AT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROW_W-1:0]      scan_addr,
  output logic [NBANKS*8-1:0]   scan_data,
  output logic                  scan_valid,
  input  logic                  host_req,
  input  logic [1:0]            host_op,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [ADDR_W-1:0]     host_src_addr,
  input  logic                  host_src_vram,
  input  logic [1:0]            host_nib,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  output logic                  host_wait
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int BANK_W = $clog2(NBANKS);

  // Slot timing
  logic scan_slot, host_slot;

  vram_slot_timer #(.PERIOD(PERIOD), .SCAN_AT(0), .HOST_AT(HOST_AT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_slot (scan_slot),
    .host_slot (host_slot)
  );

  // Host decode, named so that the checker can observe it
  host_op_e          op;
  logic              copy_stage;
  logic              src_stage;
  logic              host_fire;
  logic              host_accept;
  logic              is_read;
  logic              is_write;
  logic              acc_in;
  logic [ADDR_W-1:0] acc_addr;
  logic [BANK_W-1:0] acc_bank;
  logic [ROW_W-1:0]  acc_row;
  logic [7:0]        copy_buf;
  logic [7:0]        wr_data;

  assign op          = host_op_e'(host_op);
  assign src_stage   = (op == OP_COPY) && host_src_vram && !copy_stage;
  assign acc_addr    = src_stage ? host_src_addr : host_addr;
  assign acc_bank    = BANK_W'(bank_of(32'(acc_addr)));
  assign acc_row     = ROW_W'(row_of(32'(acc_addr)));
  assign acc_in      = in_window(32'(acc_addr), ROWS);
  assign host_fire   = host_req && host_slot;
  assign host_accept = host_fire && !src_stage;
  assign host_wait   = host_req && !host_accept;
  assign is_read     = (op == OP_READ) || src_stage;
  assign is_write    = (op == OP_WRITE) || ((op == OP_COPY) && !src_stage);
  assign wr_data     = ((op == OP_COPY) && host_src_vram) ? copy_buf : host_wdata;

  // Banks
  logic [7:0]          bank_rd   [NBANKS];
  logic [1:0]          bank_we   [NBANKS];
  logic [NBANKS-1:0]   bank_en;
  logic [NBANKS*2-1:0] bank_we_flat;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic hit;
    assign hit                    = host_fire && acc_in && (acc_bank == BANK_W'(b));
    assign bank_en[b]             = scan_slot || hit;
    assign bank_we[b]             = (hit && is_write) ? host_nib : 2'b00;
    assign bank_we_flat[2*b +: 2] = bank_we[b];

    vram_bank #(.ROW_W(ROW_W)) u_bank (
      .clk    (clk),
      .en     (bank_en[b]),
      .row    (scan_slot ? scan_addr : acc_row),
      .nib_we (bank_we[b]),
      .wdata  (wr_data),
      .rdata  (bank_rd[b])
    );
  end

  // Capture of read results
  rd_kind_e            rd_kind_q;
  logic [BANK_W-1:0]   rd_bank_q;
  logic                rd_oor_q;
  logic                scan_cap_q;
  logic [7:0]          rd_value;
  logic [NBANKS*8-1:0] scan_word;

  assign rd_value = rd_oor_q ? 8'hFF : bank_rd[rd_bank_q];

  always_comb begin
    for (int b = 0; b < NBANKS; b++) scan_word[8*b +: 8] = bank_rd[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_cap_q <= 1'b0;
      scan_valid <= 1'b0;
      scan_data  <= '0;
      rd_kind_q  <= RD_NONE;
      rd_bank_q  <= '0;
      rd_oor_q   <= 1'b0;
      host_rdata <= '0;
      copy_buf   <= '0;
      copy_stage <= 1'b0;
    end else begin
      scan_cap_q <= scan_slot;
      scan_valid <= scan_cap_q;
      if (scan_cap_q) scan_data <= scan_word;

      rd_kind_q <= RD_NONE;
      if (host_fire && is_read) begin
        rd_kind_q <= src_stage ? RD_COPY : RD_HOST;
        rd_bank_q <= acc_bank;
        rd_oor_q  <= !acc_in;
      end
      if (rd_kind_q == RD_HOST) host_rdata <= rd_value;
      if (rd_kind_q == RD_COPY) copy_buf   <= rd_value;

      if (!host_req)                  copy_stage <= 1'b0;
      else if (host_fire && src_stage) copy_stage <= 1'b1;
      else if (host_accept)           copy_stage <= 1'b0;
    end
  end
endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk #(
  parameter int PERIOD = 12,
  parameter int WE_W   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_slot,
  input logic            host_slot,
  input logic            host_req,
  input logic            host_wait,
  input logic            src_stage,
  input logic            copy_stage,
  input logic            acc_in,
  input logic [1:0]      host_nib,
  input logic [WE_W-1:0] bank_we_flat,
  input logic            scan_valid
);
  int   gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (scan_slot) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_slots_disjoint_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_slot && host_slot));

  assert_scan_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_slot && seen) |-> (gap == PERIOD - 1));

  assert_scan_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_slot |=> ##1 scan_valid);

  assert_scan_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |=> !scan_valid);

  assert_wait_off_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_slot) |-> host_wait);

  assert_nib_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_nib == 2'b00) |-> (bank_we_flat == '0));

  assert_oor_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_in |-> (bank_we_flat == '0));

  assert_copy_two_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_slot && src_stage) |=> (copy_stage && host_wait));
endmodule

bind vram_arbiter vram_arbiter_chk #(.PERIOD(PERIOD), .WE_W(NBANKS*2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scan_slot    (scan_slot),
  .host_slot    (host_slot),
  .host_req     (host_req),
  .host_wait    (host_wait),
  .src_stage    (src_stage),
  .copy_stage   (copy_stage),
  .acc_in       (acc_in),
  .host_nib     (host_nib),
  .bank_we_flat (bank_we_flat),
  .scan_valid   (scan_valid)
);

// File: tb/tb_vram_arbiter.sv
module tb_vram_arbiter;
  localparam int ROW_W  = 9;
  localparam int ROWS   = 1 << ROW_W;
  localparam int ADDR_W = 16;
  localparam int SPAN   = 3 * ROWS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ROW_W-1:0]  scan_addr = '0;
  logic [23:0]       scan_data;
  logic              scan_valid;
  logic              host_req = 1'b0;
  logic [1:0]        host_op = 2'd0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [ADDR_W-1:0] host_src_addr = '0;
  logic              host_src_vram = 1'b0;
  logic [1:0]        host_nib = 2'b00;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              host_wait;

  always #4 clk = ~clk;

  vram_arbiter #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .PERIOD(12), .HOST_AT(6)) dut (
    .clk(clk), .rst_n(rst_n), .scan_addr(scan_addr), .scan_data(scan_data),
    .scan_valid(scan_valid), .host_req(host_req), .host_op(host_op),
    .host_addr(host_addr), .host_src_addr(host_src_addr),
    .host_src_vram(host_src_vram), .host_nib(host_nib), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_wait(host_wait)
  );

  int checks = 0;
  int errors = 0;

  task automatic note(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: byte values and a known-bit mask per byte
  logic [7:0]  mv [3][ROWS];
  logic [7:0]  mk [3][ROWS];
  int          ph = 0;
  bit          cst = 0;
  logic [23:0] p_sd = '0, p_sk = '0, e_sd = '0, e_sk = '1;
  bit          e_sv = 0;
  logic [7:0]  p_rd = '0, p_rk = '0, e_rd = '0, e_rk = '1;
  bit          p_rdv = 0;
  logic [7:0]  cb = '0, cbk = '0;

  initial begin
    for (int b = 0; b < 3; b++)
      for (int r = 0; r < ROWS; r++) begin mv[b][r] = '0; mk[b][r] = '0; end
  end

  function automatic void peek(input int unsigned a, output logic [7:0] v,
                               output logic [7:0] k);
    if (a < SPAN) begin v = mv[a % 3][a / 3]; k = mk[a % 3][a / 3]; end
    else begin v = 8'hFF; k = 8'hFF; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cst = 0; e_sv = 0; e_sd = '0; e_sk = '1;
      e_rd = '0; e_rk = '1; p_rdv = 0; cb = '0; cbk = '1;
    end else begin
      logic [7:0] v, k, d, dk;
      bit srcst;
      e_sv = (ph == 1);
      if (ph == 1) begin e_sd = p_sd; e_sk = p_sk; end
      if (ph == 7 && p_rdv) begin e_rd = p_rd; e_rk = p_rk; p_rdv = 0; end
      if (ph == 0)
        for (int b = 0; b < 3; b++) begin
          p_sd[8*b +: 8] = mv[b][scan_addr];
          p_sk[8*b +: 8] = mk[b][scan_addr];
        end
      srcst = (host_op == 2'd2) && host_src_vram && !cst;
      if (host_req && ph == 6) begin
        if (srcst) begin
          peek(host_src_addr, v, k); cb = v; cbk = k;
        end else if (host_op == 2'd0) begin
          peek(host_addr, v, k); p_rd = v; p_rk = k; p_rdv = 1;
        end else if (host_op == 2'd1 || host_op == 2'd2) begin
          d  = (host_op == 2'd2 && host_src_vram) ? cb : host_wdata;
          dk = (host_op == 2'd2 && host_src_vram) ? cbk : 8'hFF;
          if (host_addr < SPAN) begin
            if (host_nib[0]) begin
              mv[host_addr % 3][host_addr / 3][3:0] = d[3:0];
              mk[host_addr % 3][host_addr / 3][3:0] = dk[3:0];
            end
            if (host_nib[1]) begin
              mv[host_addr % 3][host_addr / 3][7:4] = d[7:4];
              mk[host_addr % 3][host_addr / 3][7:4] = dk[7:4];
            end
          end
        end
      end
      if (!host_req) cst = 0;
      else if (ph == 6 && srcst) cst = 1;
      else if (ph == 6) cst = 0;
      ph = (ph + 1) % 12;
    end
  end

  // Compare against the reference in every cycle
  always @(negedge clk) begin
    bit ew;
    ew = host_req && !(ph == 6 && !((host_op == 2'd2) && host_src_vram && !cst));
    note(host_wait == ew, "R4 host_wait", 32'(host_wait), 32'(ew));
    note(scan_valid == e_sv, "R2 scan_valid", 32'(scan_valid), 32'(e_sv));
    note(((scan_data ^ e_sd) & e_sk) == '0, "R2 scan_data", 32'(scan_data), 32'(e_sd));
    note(((host_rdata ^ e_rd) & e_rk) == '0, "R5 host_rdata", 32'(host_rdata), 32'(e_rd));
  end

  // Scanner row changes at odd times
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #3;
      cyc++;
      if (cyc % 7 == 0) scan_addr = ROW_W'((cyc / 7) % 10);
    end
  end

  task automatic run_op(input logic [1:0] op, input int addr, input int src,
                        input bit srcv, input logic [1:0] nib, input logic [7:0] wd,
                        output int waits);
    @(posedge clk); #2;
    host_req = 1'b1; host_op = op; host_addr = ADDR_W'(addr);
    host_src_addr = ADDR_W'(src); host_src_vram = srcv; host_nib = nib; host_wdata = wd;
    waits = 0;
    forever begin
      @(negedge clk);
      if (host_wait) waits++;
      else break;
    end
    @(posedge clk); #2;
    host_req = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [1:0] nib, input logic [7:0] d);
    int w;
    run_op(2'd1, addr, 0, 1'b0, nib, d, w);
  endtask

  task automatic rd_check(input int addr, input logic [7:0] exp, input string tag);
    int w;
    run_op(2'd0, addr, 0, 1'b0, 2'b00, 8'h00, w);
    @(negedge clk); @(negedge clk);
    note(host_rdata == exp, tag, 32'(host_rdata), 32'(exp));
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    note(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    int w, gap;
    // R11: outputs while held in reset
    repeat (3) @(negedge clk);
    note(scan_valid == 1'b0, "R11 scan_valid", 32'(scan_valid), 0);
    note(scan_data == '0, "R11 scan_data", 32'(scan_data), 0);
    note(host_rdata == '0, "R11 host_rdata", 32'(host_rdata), 0);
    @(posedge clk); #2; rst_n = 1'b1;

    // R1: spacing of scanner strobes
    do @(negedge clk); while (!scan_valid);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!scan_valid);
    note(gap == 12, "R1 scan period", 32'(gap), 12);

    // Fill rows 0..7 of every bank with full-byte writes (R6, R3)
    for (int a = 0; a < 24; a++) wr(a, 2'b11, 8'(a * 7 + 8'h11));
    for (int a = 0; a < 24; a++) rd_check(a, 8'(a * 7 + 8'h11), "R3 R5 readback");

    // R6: single-nibble writes
    wr(4, 2'b01, 8'h3C);
    rd_check(4, 8'h2C, "R6 low nibble");
    wr(5, 2'b10, 8'h9F);
    rd_check(5, 8'h94, "R6 high nibble");

    // R7: no nibble enabled
    wr(6, 2'b00, 8'h00);
    rd_check(6, 8'h3B, "R7 write suppressed");

    // R8: out of range; 1536 would alias bank 0 row 0 if truncated
    wr(SPAN, 2'b11, 8'h00);
    rd_check(0, 8'h11, "R8 write ignored");
    rd_check(SPAN, 8'hFF, "R8 read FF");
    rd_check(16'hFFFF, 8'hFF, "R8 read top");

    // R10: copy from an external source, one slot
    run_op(2'd2, 10, 0, 1'b0, 2'b11, 8'h5A, w);
    note(w <= 11, "R10 single slot", 32'(w), 11);
    rd_check(10, 8'h5A, "R10 copy data");

    // R9: copy inside video memory, two slots
    run_op(2'd2, 9, 2, 1'b1, 2'b11, 8'h00, w);
    note(w >= 12 && w <= 23, "R9 two slots", 32'(w), 12);
    rd_check(9, 8'h1F, "R9 copy data");
    run_op(2'd2, 11, 3, 1'b1, 2'b01, 8'h00, w);
    rd_check(11, 8'h56, "R9 copy low nibble");
    run_op(2'd2, 12, SPAN + 5, 1'b1, 2'b11, 8'h00, w);
    rd_check(12, 8'hFF, "R8 copy source out of range");
    run_op(2'd2, 13, 0, 1'b1, 2'b00, 8'h00, w);
    rd_check(13, 8'(13 * 7 + 8'h11), "R7 copy suppressed");

    repeat (40) @(posedge clk);
    finish_run();
  end
endmodule